// File: doc/BRIEF.md
# Host Bridge Configuration Header Register File

This block holds the 256-byte configuration header of a host bridge function. A host-side access unit presents a dword index, four byte enables, write data and a one-cycle read or write strobe. Every byte lane is handled on its own, so byte, 16-bit and 32-bit accesses all work. Multi-byte fields are little-endian: byte enable k selects the byte at offset 4*index + k, which is write data bits 8k+7:8k.

Within one 16-bit register, each bit has its own attribute. A bit may be read-only, read/write, write-one-to-clear or a hardwired constant. Hardware events reach the block as single-cycle pulses and set sticky status flags. A system-error output combines those flags with an enable bit in the command register. Offsets outside the implemented header read as zero and ignore writes.

Top module: `hb_cfg_space`

## Requirements
- R1: Dword index 0 reads 32'h12378086, with the vendor ID in bits 15:0 and the device ID in bits 31:16. Writes to it have no effect.
- R2: The command register occupies bits 15:0 of index 1 and resets to 16'h0006. Bit 6 (parity response enable, output `perr_en_o`) is read/write. Bit 8 (system-error enable, output `serr_en_o`) is read/write. Bits 1 and 2 always read 1, and every other bit always reads 0.
- R3: The status register occupies bits 31:16 of index 1 and resets to 16'h0280. Bit 7 (reads 1), bits 10:9 (read 01) and all unlisted bits are read-only, and writes never change them.
- R4: Status bits 15, 14, 13, 12 and 8 are write-one-to-clear. Writing 1 to such a bit, with its byte enabled, clears it. Writing 0 leaves it unchanged.
- R5: Event input bits `evt_i[0]`, `[1]`, `[2]`, `[3]` and `[4]` set status bits 8, 12, 13, 14 and 15, in that order. When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: A write changes only the bytes whose enable is 1. Bytes whose enable is 0 keep their value.
- R7: Index 2 reads 32'h06000000 (revision 00h, class code 060000h) and ignores writes.
- R8: In index 3, the byte at 0Ch reads zero. Bytes 0Dh, 0Eh and 0Fh are read/write and reset to 00h.
- R9: Indices 4 through 63 read zero and ignore writes.
- R10: `serr_o` is 1 exactly when command bit 8 is 1 and at least one of status bits 15, 14, 13, 12 or 8 is set.
- R11: Read data is registered. It reflects the register state before the edge at which `rd_i` is sampled high, and it appears after that edge. At all other times it holds its value. It resets to 0.
- R12: Reset, active low, returns every register and the read data to their default values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_i | input | 6 | Dword index (byte offset bits 7:2) |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| evt_i | input | 5 | Status event pulses |
| rdata_o | output | 32 | Registered read data |
| perr_en_o | output | 1 | Command bit 6 |
| serr_en_o | output | 1 | Command bit 8 |
| serr_o | output | 1 | System-error output |

## Verification
A write or an event changes the register state at the clock edge where the strobe is sampled. The control outputs and `serr_o` therefore show the change by the next falling edge. Read data appears one edge after `rd_i` is sampled, so a directed read checks `rdata_o` at the falling edge after that rising edge. The reference model updates at every rising edge in the same order: capture the read, then apply writes, then apply events. Its outputs are compared with the design at every falling edge, where nothing is changing.

// File: rtl/hb_cfg_space.sv
module hb_cfg_space #(
  parameter logic [15:0] VENDOR_ID = 16'h8086,
  parameter logic [15:0] DEVICE_ID = 16'h1237,
  parameter logic [7:0]  REVISION  = 8'h00,
  parameter logic [23:0] CLASS     = 24'h060000,
  parameter int          IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] off_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wdata_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [4:0]       evt_i,
  output logic [31:0]      rdata_o,
  output logic             perr_en_o,
  output logic             serr_en_o,
  output logic             serr_o
);
  localparam int NFLAG = 5;

  logic             perre_q, serre_q;
  logic [NFLAG-1:0] flag_q;
  logic [7:0]       lat_q, hdr_q, bist_q;
  logic [NFLAG-1:0] clr;
  logic [15:0]      cmd_w, sts_w;
  logic [31:0]      rd_w;
  logic             wr_cs, wr_hdr;

  assign wr_cs  = wr_i && (off_i == IDX_W'(1));
  assign wr_hdr = wr_i && (off_i == IDX_W'(3));

  assign clr = (wr_cs && be_i[3]) ? {wdata_i[31:28], wdata_i[24]} : '0;

  assign cmd_w = {7'b0, serre_q, 1'b0, perre_q, 6'b000110};
  assign sts_w = {flag_q[4:1], 1'b0, 2'b01, flag_q[0], 8'h80};

  always_comb begin
    case (off_i)
      IDX_W'(0): rd_w = {DEVICE_ID, VENDOR_ID};
      IDX_W'(1): rd_w = {sts_w, cmd_w};
      IDX_W'(2): rd_w = {CLASS, REVISION};
      IDX_W'(3): rd_w = {bist_q, hdr_q, lat_q, 8'h00};
      default:   rd_w = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perre_q <= 1'b0;
      serre_q <= 1'b0;
    end else begin
      if (wr_cs && be_i[0]) perre_q <= wdata_i[6];
      if (wr_cs && be_i[1]) serre_q <= wdata_i[8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      hdr_q  <= '0;
      bist_q <= '0;
    end else begin
      if (wr_hdr && be_i[1]) lat_q  <= wdata_i[15:8];
      if (wr_hdr && be_i[2]) hdr_q  <= wdata_i[23:16];
      if (wr_hdr && be_i[3]) bist_q <= wdata_i[31:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_w;
  end

  assign perr_en_o = perre_q;
  assign serr_en_o = serre_q;
  assign serr_o    = serre_q && (|flag_q);

  logic unused_wd;
  assign unused_wd = ^{wdata_i[7], wdata_i[5:0], wdata_i[27:25], wdata_i[23:9], be_i[0] & wr_hdr};
endmodule

module hb_cfg_space_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  off_i,
  input logic [3:0]  be_i,
  input logic [31:0] wdata_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic [4:0]  evt_i,
  input logic [31:0] rdata_o,
  input logic        serr_en_o,
  input logic        serr_o,
  input logic [4:0]  flag_q
);
  a_r11_hold_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
  a_r10_serr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> serr_en_o);
  a_r1_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && off_i == 6'd0) |=> rdata_o == 32'h12378086);
  a_r2_fixed_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && off_i == 6'd1) |=> rdata_o[2:0] == 3'b110);
  a_r5_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[0] |=> flag_q[0]);
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == 6'd1 && be_i[3] && wdata_i[31] && !evt_i[4]) |=> !flag_q[4]);
endmodule

bind hb_cfg_space hb_cfg_space_chk chk_i (
  .clk(clk), .rst_n(rst_n), .off_i(off_i), .be_i(be_i), .wdata_i(wdata_i),
  .rd_i(rd_i), .wr_i(wr_i), .evt_i(evt_i), .rdata_o(rdata_o),
  .serr_en_o(serr_en_o), .serr_o(serr_o), .flag_q(flag_q)
);

// File: tb/hb_cfg_space_tb_top.sv
`timescale 1ns/1ps
module hb_cfg_space_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  off_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [4:0]  evt_i = '0;
  logic [31:0] rdata_o;
  logic        perr_en_o, serr_en_o, serr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hb_cfg_space dut_i (.*);

  // behavioural reference state
  bit       m_pe, m_se;
  bit [15:0] m_sts;
  byte unsigned m_hb[4];
  bit [31:0] m_rd;

  function automatic bit [31:0] m_word(int idx);
    bit [15:0] cmd;
    cmd = 16'h0006;
    if (m_pe) cmd = cmd + 16'h0040;
    if (m_se) cmd = cmd + 16'h0100;
    if (idx == 0) return 32'h12378086;
    if (idx == 1) return {m_sts, cmd};
    if (idx == 2) return 32'h06000000;
    if (idx == 3) return {m_hb[3], m_hb[2], m_hb[1], 8'h00};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pe = 0; m_se = 0; m_sts = 16'h0280; m_rd = 0;
      for (int k = 0; k < 4; k++) m_hb[k] = 0;
    end else begin
      if (rd_i) m_rd = m_word(int'(off_i));
      if (wr_i && off_i == 1) begin
        if (be_i[0]) m_pe = wdata_i[6];
        if (be_i[1]) m_se = wdata_i[8];
        if (be_i[3]) begin
          if (wdata_i[24]) m_sts[8] = 0;
          for (int b = 12; b < 16; b++) if (wdata_i[16+b]) m_sts[b] = 0;
        end
      end
      if (wr_i && off_i == 3)
        for (int k = 1; k < 4; k++) if (be_i[k]) m_hb[k] = wdata_i[8*k +: 8];
      if (evt_i[0]) m_sts[8] = 1;
      for (int k = 1; k < 5; k++) if (evt_i[k]) m_sts[11+k] = 1;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(rdata_o === m_rd, "R11 model rdata", rdata_o, m_rd);
    chk(serr_o === (m_se && (m_sts[8] || m_sts[15:12] != 0)), "R10 model serr", {31'b0, serr_o}, {31'b0, m_se && (m_sts[8] || m_sts[15:12] != 0)});
    chk(perr_en_o === m_pe && serr_en_o === m_se, "R2 model enables", {perr_en_o, serr_en_o}, {m_pe, m_se});
  end

  task automatic rd(int idx, logic [31:0] exp, string tag);
    @(negedge clk); off_i = 6'(idx); rd_i = 1;
    @(negedge clk); rd_i = 0;
    chk(rdata_o === exp, tag, rdata_o, exp);
  endtask

  task automatic wr(int idx, logic [3:0] be, logic [31:0] d, logic [4:0] ev = 0);
    @(negedge clk); off_i = 6'(idx); be_i = be; wdata_i = d; wr_i = 1; evt_i = ev;
    @(negedge clk); wr_i = 0; evt_i = 0;
  endtask

  task automatic pulse(logic [4:0] ev);
    @(negedge clk); evt_i = ev;
    @(negedge clk); evt_i = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rdata_o === 0 && serr_o === 0, "R12 reset outputs", rdata_o, 0);
    rd(0, 32'h12378086, "R1 id read");
    wr(0, 4'hf, 32'hffffffff);
    rd(0, 32'h12378086, "R1 id ignores write");
    rd(1, 32'h02800006, "R2 R3 reset values");
    wr(1, 4'b0011, 32'h0000ffff);
    rd(1, 32'h02800146, "R2 writable bits only");
    chk(perr_en_o && serr_en_o, "R2 enable outputs", {perr_en_o, serr_en_o}, 2'b11);
    wr(1, 4'b1100, 32'hffff0000);
    rd(1, 32'h02800146, "R3 read-only status bits");
    pulse(5'b00001);
    chk(serr_o === 1, "R10 serr asserted", serr_o, 1);
    rd(1, 32'h03800146, "R5 event bit 8");
    pulse(5'b11110);
    rd(1, 32'hf3800146, "R5 events bits 15:12");
    wr(1, 4'b1000, 32'h50000000);
    rd(1, 32'ha3800146, "R4 w1c ones clear zeros keep");
    wr(1, 4'b0111, 32'hff000000);
    rd(1, 32'ha3800006, "R6 disabled byte untouched");
    chk(serr_o === 0, "R10 serr gated off", serr_o, 0);
    wr(1, 4'b1000, 32'h01000000, 5'b00001);
    rd(1, 32'ha3800006, "R5 set wins over clear");
    wr(1, 4'b0010, 32'h00000100);
    chk(serr_o === 1, "R10 serr reenabled", serr_o, 1);
    wr(1, 4'b1000, 32'hff000000);
    rd(1, 32'h02800106, "R4 clear all flags");
    chk(serr_o === 0, "R10 no flags", serr_o, 0);
    rd(2, 32'h06000000, "R7 class read");
    wr(2, 4'hf, 32'hffffffff);
    rd(2, 32'h06000000, "R7 ignores write");
    rd(3, 32'h00000000, "R8 reset bytes");
    wr(3, 4'b1110, 32'h11223344);
    rd(3, 32'h11223300, "R8 header bytes");
    wr(3, 4'b0101, 32'haabbccdd);
    rd(3, 32'h11bb3300, "R6 byte lanes");
    rd(4, 0, "R9 reserved read");
    wr(4, 4'hf, 32'hffffffff);
    rd(4, 0, "R9 reserved ignores write");
    rd(63, 0, "R9 top index");
    rd(3, 32'h11bb3300, "R11 capture");
    repeat (4) @(negedge clk);
    chk(rdata_o === 32'h11bb3300, "R11 hold", rdata_o, 32'h11bb3300);
    pulse(5'b10000);
    rst_n = 0;
    @(negedge clk);
    chk(rdata_o === 0 && serr_o === 0, "R12 reset clears", rdata_o, 0);
    rst_n = 1;
    rd(1, 32'h02800006, "R12 status command defaults");
    rd(3, 32'h00000000, "R12 header defaults");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule